// File: doc/BRIEF.md
# Clock Power-Down and Shared-Pin Mode Controller

This block manages one active-low board pin whose meaning changes after power-up, and the orderly stopping and restarting of a clock generator's output domains. For a startup window after reset the pin is a test control: holding it low asks for every output to float. When the window ends, a configuration bit decides whether the pin keeps that role or becomes a power-down request. A qualified request stops each output domain low, one domain at a time, and then raises a stop signal for the oscillator and VCOs. Releasing the pin starts a modelled recovery delay. After that delay each domain is let through again.

All logic runs on one fast sampling clock `clk`. The reference clock, the CPU clock and each output domain's clock arrive as level inputs sampled by `clk`, so the block sees their edges. The startup window and the recovery delay are counted in reference-clock rising edges. Their parameters `STARTUP_CNT` and `RECOV_CNT` scale the millisecond-range analog times down for simulation. Gate bit i belongs to domain phase bit i. The intended order for the seven default domains is CPU, SDRAM, IOAPIC, 66 MHz hub, PCI, REF, 48 MHz, and only the number of domains matters to the logic. The outside world forms each output as `dom_ph[i] & gate[i]`.

Top module: `clkpd_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `tri_en` is 0, every `gate` bit is 1 and `vco_stop` is 0. The pin synchronizer resets to the released (high) level.
- R2: Before the startup window ends, a low level on `pin_n` drives `tri_en` to 1 two `clk` cycles later, whatever the value of `sel_pd`.
- R3: The startup window lasts `STARTUP_CNT` rising edges of `ref_ph`. It closes only in a cycle where the synchronized pin is high. While the pin is held low, the window stays open, so the tristate role persists.
- R4: Once the window has closed, `sel_pd` = 0 keeps the tristate role: `tri_en` follows the inverted pin, and no power-down occurs even while `cpu_ph` toggles. `sel_pd` = 1 gives the pin the power-down role, and `tri_en` then stays 0.
- R5: In the power-down role, power-down begins only after the pin is seen low at two consecutive rising edges of `cpu_ph`. A high pin level between the two edges restarts the count.
- R6: Each `gate` bit changes only in the cycle after its own `dom_ph` bit is seen to fall. It changes to 0 while stopping and to 1 while restarting, so no output is cut short or started with a runt pulse.
- R7: `vco_stop` rises only once every `gate` bit is 0. It stays 1 while the request is held.
- R8: On release, `vco_stop` drops while every gate is still 0. The gates stay 0 for `RECOV_CNT` rising edges of `ref_ph`, and then each gate returns to 1 under the R6 rule.
- R9: A release that arrives while domains are still being stopped does not abort the stop. `vco_stop` pulses high once all gates are 0, and then the full recovery of R8 follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_n | input | 1 | Shared active-low pin, asynchronous |
| sel_pd | input | 1 | Pin role after the window: 1 power-down, 0 tristate |
| ref_ph | input | 1 | Reference clock level, counted on rising edges |
| cpu_ph | input | 1 | CPU clock level, used to qualify the request |
| dom_ph | input | NDOM | Level of each output domain's clock |
| tri_en | output | 1 | Float all outputs (test mode) |
| gate | output | NDOM | Per-domain pass enable, 1 = clock passes |
| vco_stop | output | 1 | Stop oscillator and VCOs |

## Verification
Two functions can fall in the same stretch of cycles: stopping the domains and releasing the pin. They meet when the pin is released after the first gate has dropped but before the slowest domain has reached its falling edge. The bench forces this by releasing the pin as soon as any gate goes low. It then requires a single high pulse on `vco_stop` at a moment when every gate is low, followed by the complete recovery sequence. A monitor that runs alongside every test checks each gate transition against the falling edge of its own domain phase two samples earlier.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;
  typedef enum logic [2:0] {
    PD_RUN   = 3'd0,
    PD_STOP  = 3'd1,
    PD_OFF   = 3'd2,
    PD_WAKE  = 3'd3,
    PD_START = 3'd4
  } pd_state_e;
endpackage

// File: rtl/clkpd_pinmode.sv
module clkpd_pinmode #(
  parameter int unsigned STARTUP_CNT = 24,
  localparam int unsigned CW = $clog2(STARTUP_CNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic ref_ph,
  input  logic sel_pd,
  output logic pin_lvl,
  output logic ref_rise,
  output logic pd_func,
  output logic tri_en
);
  logic          sync1_q, sync2_q;
  logic          ref_q;
  logic [CW-1:0] win_cnt_q, win_cnt_d;
  logic          win_done_q, win_done_d;
  logic          win_full;

  assign ref_rise = ref_ph & ~ref_q;
  assign win_full = (win_cnt_q == CW'(STARTUP_CNT));

  always_comb begin
    win_cnt_d  = win_cnt_q;
    win_done_d = win_done_q;
    if (ref_rise && !win_full) begin
      win_cnt_d = win_cnt_q + 1'b1;
    end
    // window closes only while the pin is released
    if (win_full && sync2_q) begin
      win_done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= 1'b1;
      sync2_q    <= 1'b1;
      ref_q      <= 1'b0;
      win_cnt_q  <= '0;
      win_done_q <= 1'b0;
    end else begin
      sync1_q    <= pin_n;
      sync2_q    <= sync1_q;
      ref_q      <= ref_ph;
      win_cnt_q  <= win_cnt_d;
      win_done_q <= win_done_d;
    end
  end

  assign pin_lvl = sync2_q;
  assign pd_func = win_done_q & sel_pd;
  assign tri_en  = ~pd_func & ~sync2_q;
endmodule

// File: rtl/clkpd_qual.sv
module clkpd_qual #(
  parameter int unsigned SAMPLES = 2,
  localparam int unsigned QW = $clog2(SAMPLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ph,
  input  logic pin_lvl,
  input  logic pd_func,
  output logic pd_req
);
  logic          cpu_q;
  logic          cpu_rise;
  logic [QW-1:0] low_q, low_d;
  logic          low_full;

  assign cpu_rise = cpu_ph & ~cpu_q;
  assign low_full = (low_q == QW'(SAMPLES));

  always_comb begin
    low_d = low_q;
    if (!pd_func || pin_lvl) begin
      low_d = '0;
    end else if (cpu_rise && !low_full) begin
      low_d = low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= 1'b0;
      low_q <= '0;
    end else begin
      cpu_q <= cpu_ph;
      low_q <= low_d;
    end
  end

  assign pd_req = low_full;
endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
  import clkpd_pkg::*;
#(
  parameter int unsigned RECOV_CNT = 12,
  localparam int unsigned RW = $clog2(RECOV_CNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic ref_rise,
  input  logic all_off,
  input  logic all_on,
  output logic stop_req,
  output logic en_req,
  output logic vco_stop
);
  pd_state_e     state_q, state_d;
  logic [RW-1:0] rc_q, rc_d;
  logic          rc_last;

  assign rc_last = (rc_q == RW'(RECOV_CNT - 1));

  always_comb begin
    state_d = state_q;
    rc_d    = rc_q;
    unique case (state_q)
      PD_RUN:   if (pd_req) state_d = PD_STOP;
      PD_STOP:  if (all_off) state_d = PD_OFF;
      PD_OFF: begin
        if (!pd_req) begin
          state_d = PD_WAKE;
          rc_d    = '0;
        end
      end
      PD_WAKE: begin
        if (ref_rise) begin
          if (rc_last) begin
            state_d = PD_START;
            rc_d    = '0;
          end else begin
            rc_d = rc_q + 1'b1;
          end
        end
      end
      PD_START: if (all_on) state_d = PD_RUN;
      default:  state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_RUN;
      rc_q    <= '0;
    end else begin
      state_q <= state_d;
      rc_q    <= rc_d;
    end
  end

  assign stop_req = (state_q == PD_STOP);
  assign en_req   = (state_q == PD_START);
  assign vco_stop = (state_q == PD_OFF);
endmodule

// File: rtl/clkpd_gates.sv
module clkpd_gates #(
  parameter int unsigned NDOM = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDOM-1:0] dom_ph,
  input  logic            stop_req,
  input  logic            en_req,
  output logic [NDOM-1:0] gate,
  output logic            all_off,
  output logic            all_on
);
  logic [NDOM-1:0] ph_q;
  logic [NDOM-1:0] gate_q, gate_d;

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    logic fell;
    assign fell = ph_q[i] & ~dom_ph[i];

    always_comb begin
      gate_d[i] = gate_q[i];
      if (fell) begin
        if (stop_req)    gate_d[i] = 1'b0;
        else if (en_req) gate_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q[i]   <= 1'b0;
        gate_q[i] <= 1'b1;
      end else begin
        ph_q[i]   <= dom_ph[i];
        gate_q[i] <= gate_d[i];
      end
    end
  end

  assign gate    = gate_q;
  assign all_off = ~|gate_q;
  assign all_on  = &gate_q;
endmodule

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl #(
  parameter int unsigned NDOM        = 7,
  parameter int unsigned STARTUP_CNT = 24,
  parameter int unsigned RECOV_CNT   = 12,
  parameter int unsigned PD_SAMPLES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_n,
  input  logic            sel_pd,
  input  logic            ref_ph,
  input  logic            cpu_ph,
  input  logic [NDOM-1:0] dom_ph,
  output logic            tri_en,
  output logic [NDOM-1:0] gate,
  output logic            vco_stop
);
  logic pin_lvl, ref_rise, pd_func, pd_req;
  logic stop_req, en_req, all_off, all_on;

  clkpd_pinmode #(.STARTUP_CNT(STARTUP_CNT)) u_pinmode (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .ref_ph(ref_ph),
    .sel_pd(sel_pd), .pin_lvl(pin_lvl), .ref_rise(ref_rise),
    .pd_func(pd_func), .tri_en(tri_en)
  );

  clkpd_qual #(.SAMPLES(PD_SAMPLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .cpu_ph(cpu_ph), .pin_lvl(pin_lvl),
    .pd_func(pd_func), .pd_req(pd_req)
  );

  clkpd_seq #(.RECOV_CNT(RECOV_CNT)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .ref_rise(ref_rise),
    .all_off(all_off), .all_on(all_on), .stop_req(stop_req),
    .en_req(en_req), .vco_stop(vco_stop)
  );

  clkpd_gates #(.NDOM(NDOM)) u_gates (
    .clk(clk), .rst_n(rst_n), .dom_ph(dom_ph), .stop_req(stop_req),
    .en_req(en_req), .gate(gate), .all_off(all_off), .all_on(all_on)
  );
endmodule

// File: rtl/clkpd_ctrl_chk.sv
module clkpd_ctrl_chk #(
  parameter int unsigned NDOM = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pin_n,
  input logic [NDOM-1:0] dom_ph,
  input logic            tri_en,
  input logic [NDOM-1:0] gate,
  input logic            vco_stop
);
  // R2: test float only follows a pin low two samples back
  p_tri_from_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tri_en |-> !$past(pin_n, 2));

  // R7: oscillator stop only with every domain dark
  p_vco_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vco_stop |-> (gate == '0));

  // R8: oscillator resumes before any domain is let through
  p_wake_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_stop) |-> (gate == '0));

  for (genvar i = 0; i < NDOM; i++) begin : g_edge
    // R6: a gate moves only right after its own phase fell
    p_gate_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate[i]) || $rose(gate[i])) |-> ($past(dom_ph[i], 2) && !$past(dom_ph[i])));
  end
endmodule

bind clkpd_ctrl clkpd_ctrl_chk #(.NDOM(NDOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .dom_ph(dom_ph),
  .tri_en(tri_en), .gate(gate), .vco_stop(vco_stop)
);

// File: tb/clkpd_ctrl_tb_top.sv
module clkpd_ctrl_tb_top;
  localparam int NDOM        = 7;
  localparam int STARTUP_CNT = 24;
  localparam int RECOV_CNT   = 12;
  localparam logic [NDOM-1:0] ALL_ON = '1;

  // row fields: {sel_pd, pin_n, cpu_run, expected tri_en}
  localparam logic [3:0] ROWS [5] = '{4'b0011, 4'b0110, 4'b1110, 4'b1000, 4'b0001};

  logic            clk, rst_n, pin_n, sel_pd, ref_ph, cpu_ph;
  logic [NDOM-1:0] dom_ph;
  logic            tri_en, vco_stop;
  logic [NDOM-1:0] gate;
  logic            cpu_run, mon_en;
  int              pulse_req, pulse_done;
  int              checks, fails, mon_checks, mon_fails, vco_rises;

  clkpd_ctrl #(.NDOM(NDOM), .STARTUP_CNT(STARTUP_CNT), .RECOV_CNT(RECOV_CNT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .sel_pd(sel_pd), .ref_ph(ref_ph),
    .cpu_ph(cpu_ph), .dom_ph(dom_ph), .tri_en(tri_en), .gate(gate), .vco_stop(vco_stop)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    ref_ph = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      #1 ref_ph = ~ref_ph;
    end
  end

  initial begin
    int dcnt [NDOM];
    dom_ph = '0;
    for (int i = 0; i < NDOM; i++) dcnt[i] = 0;
    forever begin
      @(posedge clk);
      #1;
      for (int i = 0; i < NDOM; i++) begin
        dcnt[i]++;
        if (dcnt[i] == i + 3) begin
          dcnt[i] = 0;
          dom_ph[i] = ~dom_ph[i];
        end
      end
    end
  end

  initial begin
    cpu_ph = 1'b0;
    pulse_done = 0;
    forever begin
      repeat (2) @(posedge clk);
      #1;
      if (cpu_run) cpu_ph = ~cpu_ph;
      else if (pulse_done != pulse_req) begin
        cpu_ph = ~cpu_ph;
        if (!cpu_ph) pulse_done++;
      end else cpu_ph = 1'b0;
    end
  end

  // monitor: every gate move must follow a fall of its own phase (R6),
  // and each rise of vco_stop must find all gates dark (R7)
  initial begin
    logic [NDOM-1:0] d1, d2, g1;
    logic v1;
    d1 = '0; d2 = '0; g1 = ALL_ON; v1 = 1'b0;
    mon_checks = 0; mon_fails = 0; vco_rises = 0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        for (int i = 0; i < NDOM; i++) begin
          if (gate[i] != g1[i]) begin
            mon_checks++;
            if (!(d2[i] && !d1[i])) begin
              mon_fails++;
              $display("FAIL R6 gate %0d moved to %0b: phase history act=%0b%0b exp=10", i, gate[i], d2[i], d1[i]);
            end
          end
        end
        if (vco_stop && !v1) begin
          vco_rises++;
          mon_checks++;
          if (gate != '0) begin
            mon_fails++;
            $display("FAIL R7 vco_stop rose with gate act=%b exp=0", gate);
          end
        end
      end
      d2 = d1; d1 = dom_ph; g1 = gate; v1 = vco_stop;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_pulse();
    pulse_req++;
    for (int k = 0; k < 20 && pulse_done != pulse_req; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int rises;
    int base;
    logic rp;
    checks = 0; fails = 0; pulse_req = 0;
    rst_n = 1'b0; pin_n = 1'b1; sel_pd = 1'b0; cpu_run = 1'b0; mon_en = 1'b0;
    wait_cyc(5);
    check("R1 tri_en in reset", {31'd0, tri_en}, 32'd0);
    check("R1 gates in reset", {25'd0, gate}, {25'd0, ALL_ON});
    rst_n = 1'b1;
    wait_cyc(2);
    mon_en = 1'b1;
    check("R1 vco_stop after reset", {31'd0, vco_stop}, 32'd0);
    check("R1 gates after reset", {25'd0, gate}, {25'd0, ALL_ON});

    // R2: pin low inside the window floats outputs even with sel_pd=1
    sel_pd = 1'b1; pin_n = 1'b0;
    wait_cyc(4);
    check("R2 early tristate", {31'd0, tri_en}, 32'd1);

    // R3: window passes while pin held low -> still tristate role
    wait_cyc(250);
    check("R3 window held open", {31'd0, tri_en}, 32'd1);
    pin_n = 1'b1;
    wait_cyc(6);
    check("R3 release clears float", {31'd0, tri_en}, 32'd0);
    pin_n = 1'b0;
    wait_cyc(4);
    check("R3 pin now power-down role", {31'd0, tri_en}, 32'd0);

    // R4: table of role selections after the window
    for (int r = 0; r < 5; r++) begin
      sel_pd = ROWS[r][3]; pin_n = ROWS[r][2]; cpu_run = ROWS[r][1];
      wait_cyc(40);
      check($sformatf("R4 row %0d tri_en", r), {31'd0, tri_en}, {31'd0, ROWS[r][0]});
      check($sformatf("R4 row %0d gates", r), {24'd0, vco_stop, gate}, {25'd0, ALL_ON});
    end
    cpu_run = 1'b0;

    // R5: one low sample is not enough; a high in between restarts
    sel_pd = 1'b1; pin_n = 1'b1;
    wait_cyc(8);
    pin_n = 1'b0;
    wait_cyc(4);
    cpu_pulse();
    wait_cyc(30);
    check("R5 single low sample", {24'd0, vco_stop, gate}, {25'd0, ALL_ON});
    pin_n = 1'b1;
    wait_cyc(4);
    pin_n = 1'b0;
    wait_cyc(4);
    cpu_pulse();
    wait_cyc(30);
    check("R5 count restarted", {24'd0, vco_stop, gate}, {25'd0, ALL_ON});
    cpu_pulse();
    for (int k = 0; k < 200 && !vco_stop; k++) @(negedge clk);
    check("R5 second sample stops", {31'd0, vco_stop}, 32'd1);
    check("R7 all gates dark", {25'd0, gate}, 32'd0);
    wait_cyc(30);
    check("R7 stop held", {24'd0, vco_stop, gate}, 32'h80);

    // R8: release and recovery delay
    pin_n = 1'b1;
    for (int k = 0; k < 20 && vco_stop; k++) @(negedge clk);
    check("R8 vco resumes", {24'd0, vco_stop, gate}, 32'd0);
    rises = 0; rp = ref_ph;
    for (int k = 0; k < 400 && gate == '0; k++) begin
      @(negedge clk);
      if (ref_ph && !rp) rises++;
      rp = ref_ph;
    end
    check("R8 recovery length", {31'd0, rises >= RECOV_CNT - 1}, 32'd1);
    for (int k = 0; k < 100 && gate != ALL_ON; k++) @(negedge clk);
    check("R8 all gates back", {24'd0, vco_stop, gate}, {25'd0, ALL_ON});
    check("R8 no float", {31'd0, tri_en}, 32'd0);

    // R9: release while domains are still stopping
    base = vco_rises;
    pin_n = 1'b0; cpu_run = 1'b1;
    for (int k = 0; k < 100 && gate == ALL_ON; k++) @(negedge clk);
    pin_n = 1'b1; cpu_run = 1'b0;
    check("R9 stop under way", {31'd0, gate != ALL_ON && gate != '0}, 32'd1);
    wait_cyc(300);
    check("R9 vco pulse seen", {31'd0, vco_rises == base + 1}, 32'd1);
    check("R9 full recovery", {24'd0, vco_stop, gate}, {25'd0, ALL_ON});

    finish_run();
  end
endmodule